// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the controller-side transmitter of a time-slotted serial audio link. It runs on the link bit clock and produces two outputs: a frame-start strobe (`sync_o`) and the serial data line (`sdata_o`). Both change only on the rising edge of the bit clock. The far end samples them on the falling edge.

A frame lasts 256 bit times. It consists of a 16-bit tag slot followed by twelve 20-bit slots. The tag slot carries a frame-valid flag and one valid tag for each following slot. Slot 1 carries a register command word: the access direction and a 7-bit register index. Slot 2 carries the 16-bit write data. Slots 3 to 12 carry 16-bit samples. Every field that is not tagged valid is sent as zeros. The whole frame goes out most significant bit first.

The user presents the next frame's content on the input ports. The block pulses `frame_take_o` for one cycle, and it captures all inputs at the clock edge that closes that cycle. The frame-start strobe rises on that same edge. The first data bit follows one edge later, after the far end has seen the strobe on the falling edge in between. Input changes at any other time do not affect the frame in flight.

Top module: `aclink_tx_framer`

## Requirements
- R1: While `rst_n` is low, `sync_o`, `sdata_o` and `frame_take_o` are all 0. In the first cycle after `rst_n` rises, `frame_take_o` is 1 and `sync_o` is 0.
- R2: The inputs are captured only at the rising edge that ends a cycle in which `frame_take_o` is 1. Input changes made after that edge do not alter the frame being sent.
- R3: `sync_o` rises on the capture edge. It stays high for exactly 16 cycles and then stays low for 240 cycles.
- R4: Frame bit p (p = 0 is the first bit) is on `sdata_o` during the cycle that starts p+1 rising edges after the edge that raised `sync_o`. Bit 255 is therefore on the line during the cycle in which the next `sync_o` rise takes place.
- R5: The tag slot is frame bits 0 to 15. Bit 0 is `frm_vld_i`. Bits 1 to 12 are `slot_tag_i[0]` to `slot_tag_i[11]`, where `slot_tag_i[s-1]` tags slot s. Bits 13 to 15 are 0.
- R6: Slot 1 (frame bits 16 to 35): when `slot_tag_i[0]` is 1, the first bit is `cmd_rd_i` (1 = read, 0 = write), the next 7 bits are `cmd_idx_i` MSB first, and the last 12 bits are 0. When `slot_tag_i[0]` is 0, all 20 bits are 0.
- R7: Slot 2 (frame bits 36 to 55): when `slot_tag_i[1]` is 1 and `cmd_rd_i` is 0, the slot is `cmd_wdata_i` MSB first followed by 4 zero bits. Otherwise all 20 bits are 0. The tag of slot 1 does not affect slot 2.
- R8: Slot s, for s from 3 to 12, starts at frame bit 16+20(s-1). When `slot_tag_i[s-1]` is 1, the slot is `slot_pay_i[16(s-3)+15 : 16(s-3)]` MSB first followed by 4 zero bits. Otherwise all 20 bits are 0. As a result, frame bit 255 is always 0.
- R9: Pulses of `frame_take_o` are exactly 256 cycles apart. `frame_take_o` is high in the last cycle of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld_i | input | 1 | Frame-valid flag sent in the tag slot |
| slot_tag_i | input | 12 | Valid tag per slot; bit s-1 tags slot s |
| cmd_rd_i | input | 1 | Command direction, 1 = read, 0 = write |
| cmd_idx_i | input | 7 | Register index for the command slot |
| cmd_wdata_i | input | 16 | Register write data for slot 2 |
| slot_pay_i | input | 160 | Samples for slots 3 to 12, 16 bits each; slot 3 in the lowest bits |
| frame_take_o | output | 1 | One-cycle pulse; inputs are captured at the edge that ends it |
| sync_o | output | 1 | Frame-start strobe |
| sdata_o | output | 1 | Serial frame data, MSB first |

## Verification
The assertions assume that `rst_n` is held low for at least three clock cycles, so that no delayed term reaches back to values from before the reset. They also assume that the inputs are settled during the cycle in which `frame_take_o` is high. The check that the frame-valid flag appears two edges after the capture edge depends on this. The bench changes every input only on falling edges. It loads each frame in the middle of the take cycle and then inverts all inputs right after the capture edge. This keeps the inputs within those assumptions while still probing that capture happens only at the frame boundary. One reset is applied in mid-frame and held for three cycles.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;
    localparam int REG_IDX_W = 7;
    localparam int REG_DAT_W = 16;

    typedef struct packed {
        logic                 rd;
        logic [REG_IDX_W-1:0] idx;
        logic [REG_DAT_W-1:0] wdata;
    } cmd_t;
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
    parameter int FRAME_LEN = 256,
    parameter int SYNC_LEN  = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic take_o,
    output logic sync_o
);
    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam int RUN_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_LEN);
    localparam logic [CNT_W-1:0] CNT_RST  = CNT_W'(FRAME_LEN - 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sync;
        logic             take;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = (st_q.cnt == LAST) ? '0 : st_q.cnt + CNT_W'(1);
        st_d.sync = (st_d.cnt < SYNC_END);
        st_d.take = (st_d.cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= CNT_RST;
            st_q.sync <= 1'b0;
            st_q.take <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o = st_q.take;
    assign sync_o = st_q.sync;

    // length of the current high run of the strobe, for the width check
    logic [RUN_W-1:0] hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_run_q <= '0;
        else if (sync_o) hi_run_q <= hi_run_q + RUN_W'(1);
        else             hi_run_q <= '0;
    end

    assert_take_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_sync_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(take_o));

    assert_sync_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> (hi_run_q == RUN_W'(SYNC_LEN)));
endmodule

// File: rtl/aclink_frame_pack.sv
module aclink_frame_pack
    import aclink_tx_pkg::*;
#(
    parameter int NSLOT   = 12,
    parameter int SLOT0_W = 16,
    parameter int SLOT_W  = 20
) (
    input  logic                                 vld_i,
    input  logic [NSLOT-1:0]                     tag_i,
    input  cmd_t                                 cmd_i,
    input  logic [(NSLOT-2)*REG_DAT_W-1:0]       pay_i,
    output logic [SLOT0_W+NSLOT*SLOT_W-1:0]      frame_o
);
    localparam int FRAME_LEN = SLOT0_W + NSLOT * SLOT_W;
    localparam int PAD_W     = SLOT_W - REG_DAT_W;
    localparam int CMD_PAD_W = SLOT_W - 1 - REG_IDX_W;

    logic [SLOT_W-1:0] fld [NSLOT];

    assign fld[0] = tag_i[0] ? {cmd_i.rd, cmd_i.idx, {CMD_PAD_W{1'b0}}} : '0;
    assign fld[1] = (tag_i[1] && !cmd_i.rd) ? {cmd_i.wdata, {PAD_W{1'b0}}} : '0;

    for (genvar g = 2; g < NSLOT; g++) begin : g_data_slot
        assign fld[g] = tag_i[g] ? {pay_i[(g-2)*REG_DAT_W +: REG_DAT_W], {PAD_W{1'b0}}} : '0;
    end

    always_comb begin
        frame_o = '0;
        frame_o[FRAME_LEN-1] = vld_i;
        for (int s = 1; s <= NSLOT; s++) begin
            frame_o[FRAME_LEN-1-s] = tag_i[s-1];
        end
        for (int s = 0; s < NSLOT; s++) begin
            frame_o[FRAME_LEN-SLOT0_W-1-s*SLOT_W -: SLOT_W] = fld[s];
        end
    end
endmodule

// File: rtl/aclink_bit_shifter.sv
module aclink_bit_shifter #(
    parameter int FRAME_LEN = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [FRAME_LEN-1:0] frame_i,
    output logic                 sdata_o
);
    typedef struct packed {
        logic [FRAME_LEN-1:0] shr;
        logic                 dout;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.dout = st_q.shr[FRAME_LEN-1];
        st_d.shr  = load_i ? frame_i : {st_q.shr[FRAME_LEN-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shr  <= '0;
            st_q.dout <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata_o = st_q.dout;
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
    import aclink_tx_pkg::*;
#(
    parameter int NSLOT   = 12,
    parameter int SLOT0_W = 16,
    parameter int SLOT_W  = 20
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             frm_vld_i,
    input  logic [NSLOT-1:0]                 slot_tag_i,
    input  logic                             cmd_rd_i,
    input  logic [REG_IDX_W-1:0]             cmd_idx_i,
    input  logic [REG_DAT_W-1:0]             cmd_wdata_i,
    input  logic [(NSLOT-2)*REG_DAT_W-1:0]   slot_pay_i,
    output logic                             frame_take_o,
    output logic                             sync_o,
    output logic                             sdata_o
);
    localparam int FRAME_LEN = SLOT0_W + NSLOT * SLOT_W;

    cmd_t                 cmd;
    logic [FRAME_LEN-1:0] frame;

    assign cmd.rd    = cmd_rd_i;
    assign cmd.idx   = cmd_idx_i;
    assign cmd.wdata = cmd_wdata_i;

    aclink_frame_timer #(
        .FRAME_LEN (FRAME_LEN),
        .SYNC_LEN  (SLOT0_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_o (frame_take_o),
        .sync_o (sync_o)
    );

    aclink_frame_pack #(
        .NSLOT   (NSLOT),
        .SLOT0_W (SLOT0_W),
        .SLOT_W  (SLOT_W)
    ) u_pack (
        .vld_i   (frm_vld_i),
        .tag_i   (slot_tag_i),
        .cmd_i   (cmd),
        .pay_i   (slot_pay_i),
        .frame_o (frame)
    );

    aclink_bit_shifter #(
        .FRAME_LEN (FRAME_LEN)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (frame_take_o),
        .frame_i (frame),
        .sdata_o (sdata_o)
    );

    // last bit of every frame is reserved zero and is on the line at the strobe rise
    assert_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> !sdata_o);

    // first bit after the strobe edge is the frame-valid flag captured two edges back
    assert_vld_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_take_o, 2) |-> (sdata_o == $past(frm_vld_i, 2)));
endmodule

// File: tb/aclink_tx_framer_bench.sv
module aclink_tx_framer_bench;
    localparam int NSL = 12;
    localparam int FL  = 256;

    typedef struct packed {
        logic        vld;
        logic [11:0] tag;
        logic        rd;
        logic [6:0]  idx;
        logic [15:0] wd;
        logic [19:0] seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'hFFF, 1'b0, 7'h2A, 16'hBEEF, 20'h12345},
        '{1'b1, 12'h003, 1'b1, 7'h7F, 16'hFFFF, 20'h00000},
        '{1'b1, 12'hAAA, 1'b0, 7'h01, 16'h1234, 20'hFFFFF},
        '{1'b0, 12'h000, 1'b0, 7'h55, 16'hAAAA, 20'hABCDE},
        '{1'b1, 12'h800, 1'b1, 7'h00, 16'h0000, 20'h5A5A5},
        '{1'b1, 12'h002, 1'b0, 7'h33, 16'h8001, 20'h0F0F0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 frm_vld_i = 1'b0;
    logic [NSL-1:0]       slot_tag_i = '0;
    logic                 cmd_rd_i = 1'b0;
    logic [6:0]           cmd_idx_i = '0;
    logic [15:0]          cmd_wdata_i = '0;
    logic [(NSL-2)*16-1:0] slot_pay_i = '0;
    logic                 frame_take_o, sync_o, sdata_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    aclink_tx_framer u_aclink_tx_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_vld_i    (frm_vld_i),
        .slot_tag_i   (slot_tag_i),
        .cmd_rd_i     (cmd_rd_i),
        .cmd_idx_i    (cmd_idx_i),
        .cmd_wdata_i  (cmd_wdata_i),
        .slot_pay_i   (slot_pay_i),
        .frame_take_o (frame_take_o),
        .sync_o       (sync_o),
        .sdata_o      (sdata_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pay(input logic [19:0] seed, input int s);
        return seed[15:0] ^ 16'(s * 16'h1357) ^ {seed[19:16], 12'h000};
    endfunction

    function automatic logic [255:0] exp_frame(input vec_t v);
        logic [255:0] e = '0;
        e[255] = v.vld;
        for (int s = 1; s <= 12; s++) e[255-s] = v.tag[s-1];
        if (v.tag[0]) e[239:220] = {v.rd, v.idx, 12'h000};
        if (v.tag[1] && !v.rd) e[219:200] = {v.wd, 4'h0};
        for (int s = 3; s <= 12; s++)
            if (v.tag[s-1]) e[239-(s-1)*20 -: 20] = {pay(v.seed, s), 4'h0};
        return e;
    endfunction

    task automatic drive(input vec_t v);
        frm_vld_i   = v.vld;
        slot_tag_i  = v.tag;
        cmd_rd_i    = v.rd;
        cmd_idx_i   = v.idx;
        cmd_wdata_i = v.wd;
        for (int s = 3; s <= 12; s++) slot_pay_i[(s-3)*16 +: 16] = pay(v.seed, s);
    endtask

    task automatic scramble();
        frm_vld_i   = ~frm_vld_i;
        slot_tag_i  = ~slot_tag_i;
        cmd_rd_i    = ~cmd_rd_i;
        cmd_idx_i   = ~cmd_idx_i;
        cmd_wdata_i = ~cmd_wdata_i;
        slot_pay_i  = ~slot_pay_i;
    endtask

    // entered at a falling edge inside a take cycle; leaves at the next one
    task automatic run_frame(input vec_t v);
        logic [255:0] got = '0;
        logic [255:0] e;
        int sync_bad = 0;
        int take_bad = 0;
        drive(v);
        @(negedge clk);
        chk(sync_o === 1'b1, "R3", "strobe high after capture edge", 256'(sync_o), 256'(1));
        chk(sdata_o === 1'b0, "R8", "previous frame last bit zero", 256'(sdata_o), 256'(0));
        scramble();
        for (int i = 1; i < FL; i++) begin
            @(negedge clk);
            got[FL-i] = sdata_o;
            if (sync_o !== (i < 16)) sync_bad++;
            if (frame_take_o !== (i == FL-1)) take_bad++;
        end
        e = exp_frame(v);
        chk(got[255:240] === e[255:240], "R5", "tag slot", 256'(got[255:240]), 256'(e[255:240]));
        chk(got[239:220] === e[239:220], "R6", "command slot", 256'(got[239:220]), 256'(e[239:220]));
        chk(got[219:200] === e[219:200], "R7", "write data slot", 256'(got[219:200]), 256'(e[219:200]));
        chk(got[199:0] === e[199:0], "R8", "sample slots", 256'(got[199:0]), 256'(e[199:0]));
        chk(got === e, "R4 R2", "whole frame with inputs changed after capture", got, e);
        chk(sync_bad == 0, "R3", "strobe 16 high then low", 256'(sync_bad), 256'(0));
        chk(take_bad == 0, "R9", "take pulse spacing 256", 256'(take_bad), 256'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sync_o === 1'b0 && sdata_o === 1'b0 && frame_take_o === 1'b0, "R1", "outputs in reset",
            256'({sync_o, sdata_o, frame_take_o}), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_take_o === 1'b1 && sync_o === 1'b0, "R1", "first cycle after reset",
            256'({frame_take_o, sync_o}), 256'(2'b10));

        for (int k = 0; k < NV; k++) run_frame(VECS[k]);

        // R1: reset in mid-frame
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sync_o === 1'b0 && sdata_o === 1'b0 && frame_take_o === 1'b0, "R1", "mid-frame reset",
            256'({sync_o, sdata_o, frame_take_o}), 256'(0));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_take_o === 1'b1 && sync_o === 1'b0, "R1", "restart after mid-frame reset",
            256'({frame_take_o, sync_o}), 256'(2'b10));
        run_frame(VECS[0]);
        run_frame(VECS[1]);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule